// File: doc/BRIEF.md
# Interlocked Strobe-Pair Parallel Port

This block is a byte-wide parallel port that moves data to or from an external partner under a two-wire interlocked handshake. One wire is an active-low "data available" strobe owned by the sending side. The other is an active-high "ready" line owned by the receiving side. A direction select picks which role the port plays. When receiving, the port captures a byte from the partner and flags it for the CPU. When sending, it presents a CPU byte on the pins and steps through the strobe sequence until the partner has taken it.

Both incoming strobes pass through two-flop synchronizers before the state machines see them. Each edge of the partner is therefore acted on three clock edges after it occurs. When sending, the data sits on the pins for one full clock before the strobe falls. A CPU write made while a send is still running is held and sent once the current handshake has finished.

Top module: `hs_port`

## Requirements
- R1: After reset with `dir_out_i`=0: `rdy_o`=1, `rx_valid_o`=0, `dav_n_o`=1, `pad_data_oe_o`=0 and `tx_busy_o`=0.
- R2: In receive mode (`dir_out_i`=0), a falling `dav_n_i` captures `pad_data_i` into `cpu_rdata_o`, sets `rx_valid_o` and drives `rdy_o` low. This happens on the third rising clock edge after the fall, and not before.
- R3: While `rx_valid_o` is set, `cpu_rdata_o` keeps the captured byte even if `pad_data_i` changes after `rdy_o` has fallen.
- R4: `rdy_o` stays low until both of these hold: `rx_valid_o` has been cleared, and the synchronized `dav_n_i` is high. It rises on the clock edge after both are true.
- R5: A one-cycle `cpu_rd_i` pulse clears `rx_valid_o` on that clock edge.
- R6: In send mode (`dir_out_i`=1), a `cpu_wr_i` accepted while idle puts the byte on `pad_data_o` with `pad_data_oe_o`=1 after that edge. `dav_n_o` falls exactly one clock edge later, provided the synchronized `rdy_i` is high.
- R7: While `dav_n_o` is low, `pad_data_o` is stable. `dav_n_o` returns high on the third rising edge after `rdy_i` falls.
- R8: `dav_n_o` never falls while the synchronized `rdy_i` is low. A byte written while the partner holds `rdy_i` low waits with `dav_n_o`=1. `dav_n_o` then falls on the third edge after `rdy_i` rises.
- R9: A write accepted while a send is in progress is held. It is driven onto `pad_data_o` when the running handshake completes, which is when the synchronized `rdy_i` is high again. Its own `dav_n_o` fall follows one edge later. `tx_busy_o` stays high from the first write until the last handshake completes, three edges after the final `rdy_i` rise.
- R10: If more than one write arrives while a send is in progress, the latest written byte replaces the held one.
- R11: The unselected side is ignored. In receive mode, `cpu_wr_i` starts no transfer: `dav_n_o` stays 1, `pad_data_oe_o` stays 0 and `tx_busy_o` stays 0, even after a later switch to send mode. In send mode, `dav_n_i` activity leaves `rx_valid_o`=0 and `rdy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_out_i | input | 1 | 1 = send mode, 0 = receive mode |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle |
| cpu_wdata_i | input | DATA_W | CPU byte to send |
| cpu_rd_i | input | 1 | CPU read acknowledge, clears the receive flag |
| cpu_rdata_o | output | DATA_W | Last captured byte |
| rx_valid_o | output | 1 | Captured byte waiting for the CPU |
| tx_busy_o | output | 1 | Send in progress or held write pending |
| pad_data_i | input | DATA_W | Pin data in |
| pad_data_o | output | DATA_W | Pin data out |
| pad_data_oe_o | output | 1 | Pin output enable |
| dav_n_i | input | 1 | Partner's data-available strobe, active low |
| dav_n_o | output | 1 | Port's data-available strobe, active low |
| rdy_i | input | 1 | Partner's ready line |
| rdy_o | output | 1 | Port's ready line |

## Verification
A table of bytes is sent and received in alternating directions. Each byte is checked at the exact edge of every strobe transition, so a wrong synchronizer depth or a missing setup cycle shows up as an off-by-one. Alternating bit patterns and all-ones/all-zeros bytes expose swapped or stuck data bits. Directed sequences cover several cases:
- a partner that holds ready low before a send;
- two writes during one send, which separates a held write from a replaced one;
- a late CPU read after the strobe has already risen, which separates "either condition" from "both conditions" for the ready rise;
- writes and strobes on the unselected side.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  typedef enum logic {
    RX_READY,
    RX_HELD
  } rx_state_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SETUP,
    TX_STROBE,
    TX_RELEASE
  } tx_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hs_rx.sv
module hs_rx
  import hs_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dav_n_s_i,
  input  logic [DATA_W-1:0] pad_i,
  input  logic              rd_i,
  output logic              rdy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  rx_state_e         state_q;
  logic              dav_prev_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_READY;
      dav_prev_q <= 1'b1;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      dav_prev_q <= dav_n_s_i;
      if (!en_i) begin
        state_q <= RX_READY;
        valid_q <= 1'b0;
      end else begin
        case (state_q)
          RX_READY: begin
            if (dav_prev_q && !dav_n_s_i) begin
              data_q  <= pad_i;
              valid_q <= 1'b1;
              state_q <= RX_HELD;
            end
          end
          RX_HELD: begin
            if (rd_i) valid_q <= 1'b0;
            // release only once the CPU has consumed and the sender let go
            if (!valid_q && dav_n_s_i) state_q <= RX_READY;
          end
          default: state_q <= RX_READY;
        endcase
      end
    end
  end

  assign rdy_o   = en_i && (state_q == RX_READY);
  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/hs_tx.sv
module hs_tx
  import hs_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rdy_s_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o,
  output logic              dav_n_o,
  output logic              busy_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= TX_IDLE;
      out_q       <= '0;
      pend_data_q <= '0;
      pend_q      <= 1'b0;
    end else if (!en_i) begin
      state_q <= TX_IDLE;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (wr_i) begin
            out_q   <= wdata_i;
            state_q <= TX_SETUP;
          end else if (pend_q) begin
            out_q   <= pend_data_q;
            pend_q  <= 1'b0;
            state_q <= TX_SETUP;
          end
        end
        TX_SETUP:  if (rdy_s_i) state_q <= TX_STROBE;
        TX_STROBE: if (!rdy_s_i) state_q <= TX_RELEASE;
        TX_RELEASE: begin
          if (rdy_s_i) begin
            if (pend_q) begin
              out_q   <= pend_data_q;
              pend_q  <= 1'b0;
              state_q <= TX_SETUP;
            end else begin
              state_q <= TX_IDLE;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
      // a write during a transfer is parked; later writes overwrite it
      if (wr_i && state_q != TX_IDLE) begin
        pend_q      <= 1'b1;
        pend_data_q <= wdata_i;
      end
    end
  end

  assign data_o  = out_q;
  assign oe_o    = en_i;
  assign dav_n_o = !(en_i && state_q == TX_STROBE);
  assign busy_o  = (state_q != TX_IDLE) || pend_q;
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_out_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              rx_valid_o,
  output logic              tx_busy_o,
  input  logic [DATA_W-1:0] pad_data_i,
  output logic [DATA_W-1:0] pad_data_o,
  output logic              pad_data_oe_o,
  input  logic              dav_n_i,
  output logic              dav_n_o,
  input  logic              rdy_i,
  output logic              rdy_o
);
  localparam int NSTB = 2;

  logic [NSTB-1:0] stb_s;
  logic            dav_n_s;
  logic            rdy_s;

  hs_sync #(
    .W      (NSTB),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSTB{1'b1}})
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dav_n_i, rdy_i}),
    .q_o   (stb_s)
  );

  assign dav_n_s = stb_s[1];
  assign rdy_s   = stb_s[0];

  hs_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!dir_out_i),
    .dav_n_s_i(dav_n_s),
    .pad_i    (pad_data_i),
    .rd_i     (cpu_rd_i),
    .rdy_o    (rdy_o),
    .valid_o  (rx_valid_o),
    .data_o   (cpu_rdata_o)
  );

  hs_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (dir_out_i),
    .wr_i   (cpu_wr_i),
    .wdata_i(cpu_wdata_i),
    .rdy_s_i(rdy_s),
    .data_o (pad_data_o),
    .oe_o   (pad_data_oe_o),
    .dav_n_o(dav_n_o),
    .busy_o (tx_busy_o)
  );
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dir_out_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              rx_valid_o,
  input logic              tx_busy_o,
  input logic [DATA_W-1:0] pad_data_o,
  input logic              pad_data_oe_o,
  input logic              dav_n_o,
  input logic              rdy_o
);
  p_valid_blocks_rdy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !rdy_o);

  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(rx_valid_o)) |-> $stable(cpu_rdata_o));

  p_data_before_dav_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dav_n_o) |-> $past(pad_data_oe_o));

  p_data_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dav_n_o && $past(!dav_n_o)) |-> $stable(pad_data_o));

  p_rx_mode_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_out_i |=> !tx_busy_o);
endmodule

bind hs_port hs_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dir_out_i    (dir_out_i),
  .cpu_rdata_o  (cpu_rdata_o),
  .rx_valid_o   (rx_valid_o),
  .tx_busy_o    (tx_busy_o),
  .pad_data_o   (pad_data_o),
  .pad_data_oe_o(pad_data_oe_o),
  .dav_n_o      (dav_n_o),
  .rdy_o        (rdy_o)
);

// File: tb/test_hs_port.sv
module test_hs_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NVEC = 6;
  // {send mode, stimulus byte, expected byte}
  localparam logic [2*DW:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 8'hA5},
    {1'b0, 8'h5A, 8'h5A},
    {1'b1, 8'h3C, 8'h3C},
    {1'b1, 8'hFF, 8'hFF},
    {1'b0, 8'h00, 8'h00},
    {1'b1, 8'h81, 8'h81}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dir_out_i = 1'b0;
  logic cpu_wr_i = 1'b0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic cpu_rd_i = 1'b0;
  logic [DW-1:0] cpu_rdata_o;
  logic rx_valid_o, tx_busy_o;
  logic [DW-1:0] pad_data_i = '0;
  logic [DW-1:0] pad_data_o;
  logic pad_data_oe_o;
  logic dav_n_i = 1'b1;
  logic dav_n_o;
  logic rdy_i = 1'b1;
  logic rdy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hs_port #(.DATA_W(DW)) i_hs_port (.*);

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_dir(input logic d);
    dir_out_i = d;
    step(2);
  endtask

  task automatic rx_xfer(input logic [DW-1:0] b, input logic [DW-1:0] exp);
    pad_data_i = b;
    step(1);
    dav_n_i = 1'b0;
    step(2);
    check("R2 rdy before 3rd edge", rdy_o, 1);
    step(1);
    check("R2 rdy low", rdy_o, 0);
    check("R2 valid", rx_valid_o, 1);
    check("R2 data", cpu_rdata_o, exp);
    pad_data_i = ~b;
    step(1);
    check("R3 data hold", cpu_rdata_o, exp);
    dav_n_i = 1'b1;
    step(4);
    check("R4 rdy low while unread", rdy_o, 0);
    cpu_rd_i = 1'b1;
    step(1);
    cpu_rd_i = 1'b0;
    check("R5 valid cleared", rx_valid_o, 0);
    check("R4 rdy still low", rdy_o, 0);
    step(1);
    check("R4 rdy high", rdy_o, 1);
  endtask

  task automatic tx_xfer(input logic [DW-1:0] b, input logic [DW-1:0] exp);
    cpu_wdata_i = b;
    cpu_wr_i = 1'b1;
    step(1);
    cpu_wr_i = 1'b0;
    check("R6 data out", pad_data_o, exp);
    check("R6 oe", pad_data_oe_o, 1);
    check("R6 dav high in setup", dav_n_o, 1);
    check("R9 busy", tx_busy_o, 1);
    step(1);
    check("R6 dav low", dav_n_o, 0);
    rdy_i = 1'b0;
    step(2);
    check("R7 dav still low", dav_n_o, 0);
    step(1);
    check("R7 dav high", dav_n_o, 1);
    rdy_i = 1'b1;
    step(2);
    check("R9 busy till done", tx_busy_o, 1);
    step(1);
    check("R9 busy done", tx_busy_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    step(2);
    rst_ni = 1'b1;
    step(1);
    check("R1 rdy", rdy_o, 1);
    check("R1 valid", rx_valid_o, 0);
    check("R1 dav", dav_n_o, 1);
    check("R1 oe", pad_data_oe_o, 0);
    check("R1 busy", tx_busy_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      if (dir_out_i != VEC[i][2*DW]) set_dir(VEC[i][2*DW]);
      if (VEC[i][2*DW]) tx_xfer(VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);
      else rx_xfer(VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);
    end

    // R11: writes ignored in receive mode, strobes ignored in send mode
    set_dir(1'b0);
    cpu_wdata_i = 8'h77;
    cpu_wr_i = 1'b1;
    step(1);
    cpu_wr_i = 1'b0;
    step(3);
    check("R11 dav rx mode", dav_n_o, 1);
    check("R11 oe rx mode", pad_data_oe_o, 0);
    check("R11 busy rx mode", tx_busy_o, 0);
    set_dir(1'b1);
    step(2);
    check("R11 no late send", tx_busy_o, 0);
    check("R11 no late dav", dav_n_o, 1);
    dav_n_i = 1'b0;
    step(5);
    check("R11 rx valid in tx mode", rx_valid_o, 0);
    check("R11 rdy in tx mode", rdy_o, 0);
    dav_n_i = 1'b1;
    step(3);

    // R8: partner not ready before the send
    rdy_i = 1'b0;
    step(3);
    cpu_wdata_i = 8'hC3;
    cpu_wr_i = 1'b1;
    step(1);
    cpu_wr_i = 1'b0;
    step(4);
    check("R8 dav held high", dav_n_o, 1);
    check("R8 data waiting", pad_data_o, 8'hC3);
    rdy_i = 1'b1;
    step(2);
    check("R8 dav before 3rd edge", dav_n_o, 1);
    step(1);
    check("R8 dav low", dav_n_o, 0);
    rdy_i = 1'b0;
    step(3);
    rdy_i = 1'b1;
    step(3);
    check("R8 done", tx_busy_o, 0);

    // R9/R10: writes during a send are held; the latest wins
    cpu_wdata_i = 8'h11;
    cpu_wr_i = 1'b1;
    step(1);
    cpu_wdata_i = 8'h22;
    step(1);
    cpu_wdata_i = 8'h33;
    step(1);
    cpu_wr_i = 1'b0;
    check("R9 first byte out", pad_data_o, 8'h11);
    check("R9 dav low", dav_n_o, 0);
    rdy_i = 1'b0;
    step(3);
    check("R9 dav released", dav_n_o, 1);
    check("R9 busy pending", tx_busy_o, 1);
    rdy_i = 1'b1;
    step(2);
    check("R9 held not yet out", pad_data_o, 8'h11);
    step(1);
    check("R10 latest byte out", pad_data_o, 8'h33);
    check("R9 setup dav high", dav_n_o, 1);
    step(1);
    check("R9 held dav low", dav_n_o, 0);
    rdy_i = 1'b0;
    step(3);
    rdy_i = 1'b1;
    step(3);
    check("R9 all done", tx_busy_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule